// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block carries out one four-beat read burst from synchronous DRAM on behalf of a bus master. While it is idle, the master presents a request with a row address, a column address and a select for one of two DRAM areas. The sequencer then drives the command pins, the multiplexed address bus, the byte masks and a per-beat transfer strobe. It captures four 32-bit words from the data bus and raises a completion pulse.

Two configuration inputs set the timing, and both are sampled when a request is accepted. A 2-bit activate-to-read code sets how many cycles separate the activate command from the first read command, and no-operation commands fill any gap. Each area has its own 2-bit read latency code, and the selected area picks which one is used. Read commands are issued on four consecutive cycles. Data capture follows each read by the latency, so capture cycles overlap the later read commands. A single precharge-wait cycle closes the burst before the block returns to idle.

Top module: `sdram_burst_rd`

## Requirements
- R1: After reset, the block is idle: both chip selects and the transfer strobe are high, `ready` is high, and `beat_valid` and `done` are low.
- R2: A request accepted in idle produces an activate command (RAS low, CAS high, WE high) in the next cycle, with the row on `sd_addr` and only the chip select of the requested area low. Area 0 uses `sd_cs_n[0]` and area 1 uses `sd_cs_n[1]`.
- R3: With activate-to-read code k (0..3), exactly k NOP cycles (CS low, RAS, CAS and WE high) follow the activate, and the first read command comes k+1 cycles after it. The code is sampled at acceptance.
- R4: Four read commands (RAS high, CAS low, WE high) come on consecutive cycles. Column bits [1:0] step through col+0..col+3, wrapping modulo 4, while the upper column bits stay fixed. `sd_bs_n` is low in each read cycle and in no other cycle.
- R5: Address bit 10 is the auto-precharge flag. It is low on the first three reads and high on the fourth. The column occupies `sd_addr[8:0]`.
- R6: The latency L is 1, 2 or 3 for codes 1, 2 or 3, and a code of 0 means 1. L is taken from `cl_area0` or `cl_area1` according to the requested area and is sampled at acceptance. Data for a read issued in cycle c is captured at the end of cycle c+L. The four words come out on `beat_data` with `beat_idx` 0,1,2,3, one cycle after capture.
- R7: `done` pulses for exactly one cycle, L+1 cycles after the fourth read command, together with the last word.
- R8: The cycle that carries `done` is a precharge-wait NOP cycle. The next cycle is idle, with chip selects high and `ready` high.
- R9: A request while the block is not idle is ignored. Each burst contains exactly one activate, and its row is the one accepted.
- R10: The byte masks `sd_dqm` are all low from the activate to the precharge-wait cycle, whenever a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Burst request, taken only while `ready` |
| req_area | input | 1 | Area select (0 or 1) |
| req_row | input | 13 | Row address |
| req_col | input | 9 | Starting column address |
| rcd_code | input | 2 | Activate-to-read code, k gives k+1 cycles |
| cl_area0 | input | 2 | Read latency code for area 0 |
| cl_area1 | input | 2 | Read latency code for area 1 |
| ready | output | 1 | Idle and able to accept a request |
| sd_cs_n | output | 2 | Chip selects, one per area |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable (high for all commands used) |
| sd_dqm | output | 4 | Byte masks |
| sd_addr | output | 13 | Multiplexed address bus |
| sd_bs_n | output | 1 | Per-beat transfer strobe |
| sd_dq_in | input | 32 | Read data bus |
| beat_valid | output | 1 | Captured word present |
| beat_idx | output | 2 | Beat number of the captured word |
| beat_data | output | 32 | Captured word |
| done | output | 1 | Burst complete pulse |

## Verification
Read commands and data capture share cycles. With latency 1 the first capture falls in the same cycle as the second read command, and with latency 3 three reads are still in flight when the first capture happens. The bench runs bursts with latencies 1, 2 and 3 on both areas. Its DRAM model returns a word that encodes the row and column seen on the pins, so a capture taken one cycle early or late, or a beat issued with the wrong column, shows up in the scoreboard as a wrong word or a wrong beat order. A second overlap is checked as well: `done` must fall in the precharge-wait cycle.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACT   = 3'd1,
    ST_RCD   = 3'd2,
    ST_READ  = 3'd3,
    ST_DRAIN = 3'd4,
    ST_PREC  = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_ACT   = 2'd2,
    CMD_READ  = 2'd3
  } sd_cmd_e;

  localparam int BURST_LEN = 4;

  // latency code to cycle count; code 0 is taken as one cycle
  function automatic logic [1:0] lat_of_code(input logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction

endpackage

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_area,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [1:0]       rcd_code,
  input  logic [1:0]       cl_area0,
  input  logic [1:0]       cl_area1,
  output seq_state_e       state,
  output logic [1:0]       beat,
  output logic             area,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic [1:0]       lat,
  output logic             accept
);

  seq_state_e       state_q, state_d;
  logic [1:0]       cnt_q, cnt_d;
  logic [1:0]       beat_q, beat_d;
  logic [1:0]       rcd_q;
  logic [1:0]       lat_q;
  logic             area_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             cfg_en;

  assign cfg_en = (state_q == ST_IDLE) && req;
  assign accept = cfg_en;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req) state_d = ST_ACT;
      end
      ST_ACT: begin
        beat_d = 2'd0;
        if (rcd_q == 2'd0) begin
          state_d = ST_READ;
        end else begin
          state_d = ST_RCD;
          cnt_d   = rcd_q - 2'd1;
        end
      end
      ST_RCD: begin
        if (cnt_q == 2'd0) state_d = ST_READ;
        else               cnt_d   = cnt_q - 2'd1;
      end
      ST_READ: begin
        if (beat_q == 2'(BURST_LEN - 1)) begin
          state_d = ST_DRAIN;
          cnt_d   = lat_q - 2'd1;
        end else begin
          beat_d = beat_q + 2'd1;
        end
      end
      ST_DRAIN: begin
        if (cnt_q == 2'd0) state_d = ST_PREC;
        else               cnt_d   = cnt_q - 2'd1;
      end
      ST_PREC: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 2'd0;
      beat_q  <= 2'd0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
    end
  end

  // request registers, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcd_q  <= 2'd0;
      lat_q  <= 2'd1;
      area_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (cfg_en) begin
      rcd_q  <= rcd_code;
      lat_q  <= lat_of_code(req_area ? cl_area1 : cl_area0);
      area_q <= req_area;
      row_q  <= req_row;
      col_q  <= req_col;
    end
  end

  assign state = state_q;
  assign beat  = beat_q;
  assign area  = area_q;
  assign row   = row_q;
  assign col   = col_q;
  assign lat   = lat_q;

  // R9
  act_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACT) |-> ($past(state_q) == ST_IDLE));

  // R3
  first_read_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && beat_q == 2'd0) |->
      ($past(state_q) == ST_ACT || $past(state_q) == ST_RCD));

  // R8
  prec_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREC) |-> ($past(state_q) == ST_DRAIN));

endmodule

// File: rtl/sdram_rd_pins.sv
module sdram_rd_pins
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int N_AREA = 2,
  parameter int DQM_W  = 4
) (
  input  seq_state_e        state,
  input  logic [1:0]        beat,
  input  logic              area,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic [N_AREA-1:0] cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic              bs_n
);

  localparam logic [1:0] LAST_BEAT = 2'(BURST_LEN - 1);

  sd_cmd_e          cmd;
  logic             active;
  logic [COL_W-1:0] beat_col;

  assign active = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_IDLE: cmd = CMD_DESEL;
      ST_ACT:  cmd = CMD_ACT;
      ST_READ: cmd = CMD_READ;
      default: cmd = CMD_NOP;
    endcase
  end

  generate
    for (genvar g = 0; g < N_AREA; g++) begin : g_cs
      assign cs_n[g] = !(active && (int'(area) == g));
    end
  endgenerate

  always_comb begin
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    unique case (cmd)
      CMD_ACT:  ras_n = 1'b0;
      CMD_READ: cas_n = 1'b0;
      default: ;
    endcase
  end

  // wrapped burst column: low two bits step with the beat
  assign beat_col = {col[COL_W-1:2], 2'(col[1:0] + beat)};

  always_comb begin
    addr = '0;
    if (cmd == CMD_ACT) begin
      addr[ROW_W-1:0] = row;
    end else if (cmd == CMD_READ) begin
      addr[COL_W-1:0] = beat_col;
      addr[AP_BIT]    = (beat == LAST_BEAT);
    end
  end

  assign dqm  = active ? '0 : '1;
  assign bs_n = (cmd != CMD_READ);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W  = 32,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              issue,
  input  logic [1:0]        lat,
  input  logic [DATA_W-1:0] dq,
  output logic              beat_valid,
  output logic [1:0]        beat_idx,
  output logic [DATA_W-1:0] beat_data,
  output logic              done
);

  logic [MAX_LAT-1:0] pipe_q;
  logic [1:0]         lat_idx;
  logic               grab;
  logic [1:0]         cnt_q;
  logic               valid_q, done_q;
  logic [1:0]         idx_q;
  logic [DATA_W-1:0]  data_q;

  // pipe_q[i] is set i+1 cycles after a read command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[MAX_LAT-2:0], issue};
  end

  assign lat_idx = lat - 2'd1;
  assign grab    = pipe_q[lat_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= 2'd0;
    else if (start) cnt_q <= 2'd0;
    else if (grab)  cnt_q <= cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= grab;
      done_q  <= grab && (cnt_q == 2'd3);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 2'd0;
      data_q <= '0;
    end else if (grab) begin
      idx_q  <= cnt_q;
      data_q <= dq;
    end
  end

  assign beat_valid = valid_q;
  assign beat_idx   = idx_q;
  assign beat_data  = data_q;
  assign done       = done_q;

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int ADDR_W  = 13,
  parameter int AP_BIT  = 10,
  parameter int DATA_W  = 32,
  parameter int N_AREA  = 2,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_area,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        rcd_code,
  input  logic [1:0]        cl_area0,
  input  logic [1:0]        cl_area1,
  output logic              ready,
  output logic [N_AREA-1:0] sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [DATA_W/8-1:0] sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_bs_n,
  input  logic [DATA_W-1:0] sd_dq_in,
  output logic              beat_valid,
  output logic [1:0]        beat_idx,
  output logic [DATA_W-1:0] beat_data,
  output logic              done
);

  localparam int DQM_W = DATA_W / 8;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_state_e       st;
  logic [1:0]       beat;
  logic             area;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [1:0]       lat;
  logic             accept;

  sdram_rd_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (req),
    .req_area (req_area),
    .req_row  (req_row),
    .req_col  (req_col),
    .rcd_code (rcd_code),
    .cl_area0 (cl_area0),
    .cl_area1 (cl_area1),
    .state    (st),
    .beat     (beat),
    .area     (area),
    .row      (row),
    .col      (col),
    .lat      (lat),
    .accept   (accept)
  );

  sdram_rd_pins #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT), .N_AREA(N_AREA), .DQM_W(DQM_W)
  ) u_pins (
    .state (st),
    .beat  (beat),
    .area  (area),
    .row   (row),
    .col   (col),
    .cs_n  (sd_cs_n),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .dqm   (sd_dqm),
    .addr  (sd_addr),
    .bs_n  (sd_bs_n)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT)) u_cap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (accept),
    .issue      (st == ST_READ),
    .lat        (lat),
    .dq         (sd_dq_in),
    .beat_valid (beat_valid),
    .beat_idx   (beat_idx),
    .beat_data  (beat_data),
    .done       (done)
  );

  assign ready = (st == ST_IDLE);

  // R7
  done_in_prec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (st == ST_PREC));

  // R6
  capture_window_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid |-> ($past(st) == ST_READ || $past(st) == ST_DRAIN));

endmodule

// File: tb/test_sdram_burst_rd.sv
module test_sdram_burst_rd;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic        req_area;
  logic [12:0] req_row;
  logic [8:0]  req_col;
  logic [1:0]  rcd_code, cl_area0, cl_area1;
  logic        ready;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [3:0]  sd_dqm;
  logic [12:0] sd_addr;
  logic        sd_bs_n;
  logic [31:0] sd_dq_in;
  logic        beat_valid;
  logic [1:0]  beat_idx;
  logic [31:0] beat_data;
  logic        done;

  always #2.5 clk = ~clk;

  sdram_burst_rd i_sdram_burst_rd (
    .clk(clk), .rst_n(rst_n), .req(req), .req_area(req_area),
    .req_row(req_row), .req_col(req_col), .rcd_code(rcd_code),
    .cl_area0(cl_area0), .cl_area1(cl_area1), .ready(ready),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_addr(sd_addr),
    .sd_bs_n(sd_bs_n), .sd_dq_in(sd_dq_in), .beat_valid(beat_valid),
    .beat_idx(beat_idx), .beat_data(beat_data), .done(done)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [12:0] r, input logic a, input logic [8:0] c);
    return {r, 3'b101, 6'd0, a, c};
  endfunction

  // scoreboard: {beat, word}
  logic [33:0] exp_q[$];

  // monitor / DRAM model log
  int          cyc = 0;
  int          cur_lat = 1;
  bit          logging = 0;
  int          act_cnt, act_cyc, nop_cnt, rd_n, done_cnt, done_cyc, idle_cyc;
  int          bs_err, dqm_err;
  bit          tpc_nop;
  logic [12:0] act_row;
  logic [1:0]  act_cs;
  int          rd_cyc[4];
  logic [12:0] rd_addr[4];
  logic [31:0] sched[8];
  bit          sched_v[8];

  always @(negedge clk) begin
    bit is_rd, is_act, is_nop, sel;
    cyc++;
    if (sched_v[cyc % 8]) begin
      sd_dq_in = sched[cyc % 8];
      sched_v[cyc % 8] = 0;
    end else begin
      sd_dq_in = 32'hBAD0_0000 ^ 32'(cyc);
    end
    sel    = (sd_cs_n != 2'b11);
    is_act = sel && !sd_ras_n && sd_cas_n && sd_we_n;
    is_rd  = sel && sd_ras_n && !sd_cas_n && sd_we_n;
    is_nop = sel && sd_ras_n && sd_cas_n && sd_we_n;
    if (logging) begin
      if (is_act) begin
        act_cnt++; act_cyc = cyc; act_row = sd_addr; act_cs = sd_cs_n;
      end
      if (is_nop && rd_n == 0 && act_cnt > 0) nop_cnt++;
      if (is_rd && rd_n < 4) begin
        rd_cyc[rd_n] = cyc; rd_addr[rd_n] = sd_addr; rd_n++;
        sched[(cyc + cur_lat) % 8]   = word_of(act_row, !act_cs[1] ? 1'b1 : 1'b0, sd_addr[8:0]);
        sched_v[(cyc + cur_lat) % 8] = 1;
      end
      if (!sd_bs_n != is_rd) bs_err++;
      if (sel && sd_dqm != 4'd0) dqm_err++;
      if (done) begin
        done_cnt++; done_cyc = cyc; tpc_nop = is_nop;
      end
      if (done_cnt > 0 && idle_cyc == 0 && ready && sd_cs_n == 2'b11) idle_cyc = cyc;
    end
    if (beat_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected beat", longint'(beat_data), 0);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        check(beat_idx == e[33:32], "R6 beat order", beat_idx, e[33:32]);
        check(beat_data == e[31:0], "R6 beat data", beat_data, e[31:0]);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic run_read(input logic a, input logic [12:0] r, input logic [8:0] c,
                          input logic [1:0] rcd, input logic [1:0] c0, input logic [1:0] c1);
    int lat;
    lat = int'(a ? c1 : c0);
    if (lat == 0) lat = 1;
    act_cnt = 0; nop_cnt = 0; rd_n = 0; done_cnt = 0; done_cyc = 0; idle_cyc = 0;
    bs_err = 0; dqm_err = 0; tpc_nop = 0; act_cyc = 0;
    cur_lat = lat; logging = 1;
    for (int b = 0; b < 4; b++) begin
      logic [8:0] cb;
      cb = {c[8:2], 2'(c[1:0] + 2'(b))};
      exp_q.push_back({2'(b), word_of(r, a, cb)});
    end
    req = 1; req_area = a; req_row = r; req_col = c;
    rcd_code = rcd; cl_area0 = c0; cl_area1 = c1;
    tick();
    // R9: keep requesting with other values while busy; R3/R6 sampling
    req_row = ~r; req_area = ~a; rcd_code = ~rcd; cl_area0 = ~c0; cl_area1 = ~c1;
    for (int i = 0; i < 3; i++) tick();
    req = 0;
    for (int i = 0; i < 40 && idle_cyc == 0; i++) tick();
    logging = 0;
    check(act_cnt == 1, "R9 single activate", act_cnt, 1);
    check(act_row == r, "R2 row on activate", act_row, r);
    check(act_cs == (a ? 2'b01 : 2'b10), "R2 area chip select", act_cs, a ? 2'b01 : 2'b10);
    check(nop_cnt == int'(rcd), "R3 gap NOPs", nop_cnt, rcd);
    check(rd_cyc[0] - act_cyc == int'(rcd) + 1, "R3 act to read", rd_cyc[0] - act_cyc, rcd + 1);
    check(rd_n == 4, "R4 read count", rd_n, 4);
    for (int b = 0; b < 4; b++) begin
      logic [8:0] cb;
      cb = {c[8:2], 2'(c[1:0] + 2'(b))};
      check(rd_cyc[b] == rd_cyc[0] + b, "R4 consecutive reads", rd_cyc[b], rd_cyc[0] + b);
      check(rd_addr[b][8:0] == cb, "R4 column", rd_addr[b][8:0], cb);
      check(rd_addr[b][10] == (b == 3), "R5 precharge flag", rd_addr[b][10], b == 3);
    end
    check(bs_err == 0, "R4 strobe", bs_err, 0);
    check(done_cnt == 1, "R7 done pulses", done_cnt, 1);
    check(done_cyc - rd_cyc[3] == lat + 1, "R7 done timing", done_cyc - rd_cyc[3], lat + 1);
    check(tpc_nop, "R8 precharge wait NOP", tpc_nop, 1);
    check(idle_cyc == done_cyc + 1, "R8 idle after wait", idle_cyc, done_cyc + 1);
    check(dqm_err == 0, "R10 byte masks", dqm_err, 0);
    check(exp_q.size() == 0, "R6 all words", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) sched_v[i] = 0;
    rst_n = 0; req = 0; req_area = 0; req_row = '0; req_col = '0;
    rcd_code = 0; cl_area0 = 0; cl_area1 = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R1
    check(sd_cs_n == 2'b11, "R1 chip selects", sd_cs_n, 2'b11);
    check(ready, "R1 ready", ready, 1);
    check(sd_bs_n, "R1 strobe", sd_bs_n, 1);
    check(!beat_valid && !done, "R1 no output", {beat_valid, done}, 0);
    run_read(1'b0, 13'h1A5B, 9'h0F0, 2'd0, 2'd0, 2'd3); // code 0 -> L=1
    run_read(1'b1, 13'h0777, 9'h122, 2'd3, 2'd1, 2'd3);
    run_read(1'b0, 13'h1FFF, 9'h1FD, 2'd1, 2'd2, 2'd1);
    run_read(1'b1, 13'h0001, 9'h003, 2'd2, 2'd3, 2'd1);
    run_read(1'b0, 13'h0ABC, 9'h0AB, 2'd3, 2'd3, 2'd2);
    run_read(1'b1, 13'h1234, 9'h1FE, 2'd0, 2'd1, 2'd2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule